// File: doc/BRIEF.md
# Big-Endian Load/Store Address Unit

This unit sits between the operand read stage of a 32-bit big-endian RISC core and a 32-bit word-wide data memory port. It accepts one memory command at a time. Each command carries two register operands, a 13-bit signed immediate, an immediate-select flag, an access size, a signed flag and a load/store flag. The unit forms the effective byte address, either base plus index or base plus sign-extended immediate. It rejects addresses that are not aligned to the access size. It then runs the access on the memory port.

On a store, the unit places the datum in the big-endian byte lanes and drives the matching byte enables. On a load, it extracts the addressed bytes from the returned word and zero- or sign-extends them. A doubleword access runs as two word beats: the even register at the effective address, then the odd register at the effective address plus 4.

The command input is valid/ready. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the unit is idle, so the producer must hold its command and all its fields until that edge.

The memory request is also valid/ready. Once `mem_req` is raised, the address, write flag, byte enables and write data stay fixed until an edge with `mem_ready` high. Read data returns on `mem_rvalid` at least one cycle after the request is accepted. The load-result output has no back-pressure: its consumer, a register-file write port, takes every `res_valid` pulse.

Top module: `be_mem_access_unit`

## Requirements
- R1: With `cmd_imm_sel`=0, the effective address is `cmd_rs1 + cmd_rs2` modulo 2^32.
- R2: With `cmd_imm_sel`=1, the effective address is `cmd_rs1` plus `cmd_imm` sign-extended from bit 12, giving offsets from -4096 to +4095. `cmd_rs2` has no effect on the address in this mode.
- R3: Size encoding is 00 byte, 01 halfword, 10 word, 11 doubleword. A halfword needs address bit 0 clear, a word needs bits 1..0 clear, and a doubleword needs bits 2..0 clear. A violating command still transfers. It raises `misalign` for exactly the cycle after acceptance, issues no memory request, and leaves the unit idle and ready.
- R4: A store drives `mem_we`=1 and active-high `mem_be`, where bit 3 enables memory bits 31..24 and bit 0 enables bits 7..0. A byte at offset k (address bits 1..0) enables bit 3-k. A halfword at offset 0 enables 1100, and at offset 2 enables 0011. A word enables 1111. The datum, taken from the low bits of the write-data operand, is repeated across all four lanes.
- R5: A load drives `mem_we`=0. A byte at offset k is taken from bits 31-8k..24-8k of the returned word. A halfword at offset 0 is taken from bits 31..16, and at offset 2 from bits 15..0.
- R6: Byte and halfword load results are sign-extended when `cmd_signed`=1 and zero-extended when it is 0. Word and doubleword results pass through unchanged.
- R7: A doubleword access issues two requests, the first at the effective address and the second at that address plus 4. A store sends `cmd_wdata_even` then `cmd_wdata_odd` with all byte enables set. A load returns two results, the first with `res_odd`=0 and the second with `res_odd`=1.
- R8: `busy` is high from the edge after a command is accepted until its last beat completes, including the time between doubleword beats. `cmd_ready` is low whenever `busy` is high. While `mem_req` is high without `mem_ready`, the request stays raised with an unchanged address.
- R9: `res_valid` pulses for one cycle, exactly one cycle after each cycle in which `mem_rvalid` answers an outstanding read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command can transfer |
| cmd_store | input | 1 | 1 store, 0 load |
| cmd_size | input | 2 | Access size: 00 byte, 01 half, 10 word, 11 double |
| cmd_signed | input | 1 | Sign-extend narrow load results |
| cmd_imm_sel | input | 1 | Use immediate instead of second register |
| cmd_rs1 | input | 32 | Base register value |
| cmd_rs2 | input | 32 | Index register value |
| cmd_imm | input | 13 | Signed immediate offset |
| cmd_wdata_even | input | 32 | Store data (first beat, or only beat) |
| cmd_wdata_odd | input | 32 | Store data for second doubleword beat |
| mem_req | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_addr | output | 32 | Byte address of the request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_be | output | 4 | Byte-lane enables, bit 3 = bits 31..24 |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Returned word |
| res_valid | output | 1 | Load result valid pulse |
| res_odd | output | 1 | Result belongs to odd register of a pair |
| res_data | output | 32 | Extended load result |
| misalign | output | 1 | Alignment violation pulse |
| busy | output | 1 | Access in progress |

## Verification
The bench builds the unit with its default widths: 32-bit address, 32-bit data and a 13-bit immediate. This makes the immediate extremes -4096 and +4095 reachable, along with every byte and halfword lane offset and the carry from offset into the base. The bench's memory responder inserts 0 to 2 stall cycles before accepting a request. This exercises request holding and the `busy` window across doubleword beats. The responder's read data depends on the address, so narrow loads return both positive and negative lane values and both extension modes are exercised.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_WAIT = 2'b10
  } lsu_state_e;

endpackage

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen
  import be_lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 13
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              imm_sel_i,
  input  acc_size_e         size_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              bad_align_o
);
  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] imm_ext;
  logic [ADDR_W-1:0] offset;

  assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign offset  = imm_sel_i ? imm_ext : index_i;
  assign ea_o    = base_i + offset;

  always_comb begin
    unique case (size_i)
      SZ_BYTE:  bad_align_o = 1'b0;
      SZ_HALF:  bad_align_o = ea_o[0];
      SZ_WORD:  bad_align_o = |ea_o[1:0];
      default:  bad_align_o = |ea_o[2:0];
    endcase
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import be_lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_size_e                       size_i,
  input  logic [$clog2(DATA_W/8)-1:0]     off_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W/8-1:0]             be_o,
  output logic [DATA_W-1:0]               lane_data_o
);
  localparam int LANES = DATA_W / 8;
  localparam logic [LANES-1:0] BYTE_TOP = {1'b1, {(LANES-1){1'b0}}};
  localparam logic [LANES-1:0] HALF_TOP = {2'b11, {(LANES-2){1'b0}}};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        be_o        = BYTE_TOP >> off_i;
        lane_data_o = {LANES{wdata_i[7:0]}};
      end
      SZ_HALF: begin
        be_o        = HALF_TOP >> off_i;
        lane_data_o = {(LANES/2){wdata_i[15:0]}};
      end
      default: begin
        be_o        = '1;
        lane_data_o = wdata_i;
      end
    endcase
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import be_lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_size_e                   size_i,
  input  logic [$clog2(DATA_W/8)-1:0] off_i,
  input  logic                        sgn_i,
  input  logic [DATA_W-1:0]           rdata_i,
  output logic [DATA_W-1:0]           data_o
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic [7:0]       lane [LANES];
  logic [7:0]       sel_byte;
  logic [15:0]      sel_half;
  logic [OFF_W-1:0] hi_idx;
  logic [OFF_W-1:0] lo_idx;

  // lane 0 is the most significant byte of the word
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = rdata_i[DATA_W-1-8*g -: 8];
  end

  assign hi_idx   = {off_i[OFF_W-1:1], 1'b0};
  assign lo_idx   = {off_i[OFF_W-1:1], 1'b1};
  assign sel_byte = lane[off_i];
  assign sel_half = {lane[hi_idx], lane[lo_idx]};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = {{(DATA_W-8){sgn_i & sel_byte[7]}}, sel_byte};
      SZ_HALF: data_o = {{(DATA_W-16){sgn_i & sel_half[15]}}, sel_half};
      default: data_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/be_mem_access_unit.sv
module be_mem_access_unit
  import be_lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_store,
  input  logic [1:0]          cmd_size,
  input  logic                cmd_signed,
  input  logic                cmd_imm_sel,
  input  logic [ADDR_W-1:0]   cmd_rs1,
  input  logic [ADDR_W-1:0]   cmd_rs2,
  input  logic [IMM_W-1:0]    cmd_imm,
  input  logic [DATA_W-1:0]   cmd_wdata_even,
  input  logic [DATA_W-1:0]   cmd_wdata_odd,
  output logic                mem_req,
  input  logic                mem_ready,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_we,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic                mem_rvalid,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                res_valid,
  output logic                res_odd,
  output logic [DATA_W-1:0]   res_data,
  output logic                misalign,
  output logic                busy
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  lsu_state_e        state_q;
  logic [ADDR_W-1:0] base_q;
  acc_size_e         size_q;
  logic              sgn_q;
  logic              st_q;
  logic [DATA_W-1:0] wd_even_q;
  logic [DATA_W-1:0] wd_odd_q;
  logic              beat_q;
  logic              res_valid_q;
  logic              res_odd_q;
  logic [DATA_W-1:0] res_data_q;
  logic              mis_q;

  logic [ADDR_W-1:0] ea;
  logic              ea_bad;
  logic              last_beat;
  logic [DATA_W-1:0] beat_wdata;
  logic [DATA_W-1:0] ext_data;
  logic [OFF_W-1:0]  lane_off;

  lsu_ea_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_ea (
    .base_i      (cmd_rs1),
    .index_i     (cmd_rs2),
    .imm_i       (cmd_imm),
    .imm_sel_i   (cmd_imm_sel),
    .size_i      (acc_size_e'(cmd_size)),
    .ea_o        (ea),
    .bad_align_o (ea_bad)
  );

  assign lane_off   = base_q[OFF_W-1:0];
  assign beat_wdata = beat_q ? wd_odd_q : wd_even_q;

  lsu_store_lanes #(.DATA_W(DATA_W)) u_st (
    .size_i      (size_q),
    .off_i       (lane_off),
    .wdata_i     (beat_wdata),
    .be_o        (mem_be),
    .lane_data_o (mem_wdata)
  );

  lsu_load_extract #(.DATA_W(DATA_W)) u_ld (
    .size_i  (size_q),
    .off_i   (lane_off),
    .sgn_i   (sgn_q),
    .rdata_i (mem_rdata),
    .data_o  (ext_data)
  );

  assign last_beat = (size_q != SZ_DWORD) || beat_q;
  assign cmd_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign mem_req   = (state_q == ST_REQ);
  assign mem_we    = st_q;
  assign mem_addr  = base_q + {{(ADDR_W-3){1'b0}}, beat_q, 2'b00};
  assign res_valid = res_valid_q;
  assign res_odd   = res_odd_q;
  assign res_data  = res_data_q;
  assign misalign  = mis_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      base_q      <= '0;
      size_q      <= SZ_BYTE;
      sgn_q       <= 1'b0;
      st_q        <= 1'b0;
      wd_even_q   <= '0;
      wd_odd_q    <= '0;
      beat_q      <= 1'b0;
      res_valid_q <= 1'b0;
      res_odd_q   <= 1'b0;
      res_data_q  <= '0;
      mis_q       <= 1'b0;
    end else begin
      res_valid_q <= 1'b0;
      mis_q       <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            if (ea_bad) begin
              mis_q <= 1'b1;
            end else begin
              base_q    <= ea;
              size_q    <= acc_size_e'(cmd_size);
              sgn_q     <= cmd_signed;
              st_q      <= cmd_store;
              wd_even_q <= cmd_wdata_even;
              wd_odd_q  <= cmd_wdata_odd;
              beat_q    <= 1'b0;
              state_q   <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_ready) begin
            if (!st_q) begin
              state_q <= ST_WAIT;
            end else if (last_beat) begin
              state_q <= ST_IDLE;
            end else begin
              beat_q <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (mem_rvalid) begin
            res_valid_q <= 1'b1;
            res_odd_q   <= beat_q;
            res_data_q  <= ext_data;
            if (last_beat) begin
              state_q <= ST_IDLE;
            end else begin
              beat_q  <= 1'b1;
              state_q <= ST_REQ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R8
  AST_MISALIGN_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> !mem_req && cmd_ready); // R3
  AST_WIDE_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && (size_q == SZ_WORD || size_q == SZ_DWORD) |-> mem_addr[1:0] == 2'b00); // R3
  AST_SECOND_BEAT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && beat_q |-> mem_addr[2:0] == 3'b100); // R7
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && size_q == SZ_BYTE |-> $countones(mem_be) == 1); // R4
  AST_RES_AFTER_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(mem_rvalid)); // R9
endmodule

// File: tb/be_mem_access_unit_tb.sv
module be_mem_access_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic        sg;
    logic        im;
    logic [31:0] a;
    logic [31:0] b;
    logic [12:0] imm;
    logic [31:0] wde;
    logic [31:0] wdo;
    logic [1:0]  stall;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 1'b1, 1'b0, 32'h0000_1000, 32'h0000_0002, 13'h0000, 32'h0, 32'h0, 2'd0},
    '{1'b0, 2'd0, 1'b0, 1'b1, 32'h0000_2000, 32'hDEAD_BEEF, 13'h1FFF, 32'h0, 32'h0, 2'd1},
    '{1'b0, 2'd1, 1'b1, 1'b1, 32'h0000_3000, 32'h1234_5678, 13'h1000, 32'h0, 32'h0, 2'd0},
    '{1'b0, 2'd1, 1'b0, 1'b0, 32'h0000_4000, 32'h0000_0002, 13'h0000, 32'h0, 32'h0, 2'd2},
    '{1'b0, 2'd2, 1'b1, 1'b1, 32'h0000_5001, 32'h0000_0000, 13'h0FFF, 32'h0, 32'h0, 2'd0},
    '{1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_1003, 32'h0000_0000, 13'h0000, 32'h0, 32'h0, 2'd0},
    '{1'b1, 2'd0, 1'b0, 1'b0, 32'h0000_6000, 32'h0000_0001, 13'h0000, 32'h0000_00A7, 32'h0, 2'd0},
    '{1'b1, 2'd0, 1'b0, 1'b1, 32'h0000_6100, 32'h0000_0040, 13'h0003, 32'h1234_56C4, 32'h0, 2'd1},
    '{1'b1, 2'd1, 1'b0, 1'b0, 32'h0000_6200, 32'h0000_0002, 13'h0000, 32'hFFFF_BEEF, 32'h0, 2'd0},
    '{1'b1, 2'd1, 1'b0, 1'b1, 32'h0000_6304, 32'h0000_0000, 13'h1FFC, 32'h0000_1357, 32'h0, 2'd2},
    '{1'b1, 2'd2, 1'b0, 1'b0, 32'h0000_6404, 32'h0000_0004, 13'h0000, 32'hCAFE_F00D, 32'h0, 2'd0},
    '{1'b1, 2'd3, 1'b0, 1'b1, 32'h0000_7010, 32'h0000_0003, 13'h0008, 32'h1111_2222, 32'h3333_4444, 2'd1},
    '{1'b0, 2'd3, 1'b1, 1'b0, 32'h0000_8000, 32'h0000_0020, 13'h0000, 32'h0, 32'h0, 2'd2},
    '{1'b0, 2'd1, 1'b0, 1'b0, 32'h0000_9000, 32'h0000_0001, 13'h0000, 32'h0, 32'h0, 2'd0},
    '{1'b0, 2'd2, 1'b0, 1'b1, 32'h0000_9000, 32'h0000_0000, 13'h0002, 32'h0, 32'h0, 2'd0},
    '{1'b1, 2'd3, 1'b0, 1'b0, 32'h0000_9000, 32'h0000_0004, 13'h0000, 32'h5, 32'h6, 2'd0},
    '{1'b0, 2'd1, 1'b1, 1'b1, 32'h0000_A004, 32'h0000_0000, 13'h1FFE, 32'h0, 32'h0, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_store = 1'b0;
  logic [1:0]  cmd_size = 2'd0;
  logic        cmd_signed = 1'b0;
  logic        cmd_imm_sel = 1'b0;
  logic [31:0] cmd_rs1 = '0;
  logic [31:0] cmd_rs2 = '0;
  logic [12:0] cmd_imm = '0;
  logic [31:0] cmd_wdata_even = '0;
  logic [31:0] cmd_wdata_odd = '0;
  logic        mem_req;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        res_valid;
  logic        res_odd;
  logic [31:0] res_data;
  logic        misalign;
  logic        busy;

  be_mem_access_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_store(cmd_store),
    .cmd_size(cmd_size), .cmd_signed(cmd_signed), .cmd_imm_sel(cmd_imm_sel),
    .cmd_rs1(cmd_rs1), .cmd_rs2(cmd_rs2), .cmd_imm(cmd_imm),
    .cmd_wdata_even(cmd_wdata_even), .cmd_wdata_odd(cmd_wdata_odd),
    .mem_req(mem_req), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_odd(res_odd), .res_data(res_data),
    .misalign(misalign), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // observation logs filled by the memory responder
  logic [31:0] t_addr [4];
  logic        t_we   [4];
  logic [3:0]  t_be   [4];
  logic [31:0] t_wd   [4];
  logic [31:0] r_data [4];
  logic        r_odd  [4];
  int n_txn = 0, n_res = 0, n_mis = 0;
  int cur_stall = 0, wcnt = 0;
  logic rd_pending = 1'b0;
  logic [31:0] rd_addr = '0;
  int rv_cyc = -10;
  int timing_viol = 0, hold_viol = 0, ready_viol = 0, gap_viol = 0;
  logic prev_stalled = 1'b0;
  logic [31:0] prev_addr = '0;
  logic in_dword = 1'b0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[7:0] ^ 8'hF0, a[7:0] ^ 8'h3C, a[7:0] ^ 8'h81, a[7:0] ^ 8'h5A};
  endfunction

  always @(negedge clk) begin
    mem_rvalid = rd_pending;
    mem_rdata  = rd_pending ? mem_word({rd_addr[31:2], 2'b00}) : 32'h0;
    rd_pending = 1'b0;
    if (mem_rvalid) rv_cyc = cyc;
    if (res_valid) begin
      if (n_res < 4) begin r_data[n_res] = res_data; r_odd[n_res] = res_odd; end
      n_res++;
      if (cyc != rv_cyc + 1) timing_viol++;
    end
    if (misalign) n_mis++;
    if (busy && cmd_ready) ready_viol++;
    if (in_dword && n_txn == 1 && !busy) gap_viol++;
    if (prev_stalled && (!mem_req || mem_addr != prev_addr)) hold_viol++;
    if (mem_req) begin
      if (wcnt >= cur_stall) begin
        mem_ready = 1'b1;
        wcnt = 0;
        if (n_txn < 4) begin
          t_addr[n_txn] = mem_addr; t_we[n_txn] = mem_we;
          t_be[n_txn] = mem_be; t_wd[n_txn] = mem_wdata;
        end
        n_txn++;
        if (!mem_we) begin rd_pending = 1'b1; rd_addr = mem_addr; end
      end else begin
        mem_ready = 1'b0;
        wcnt++;
      end
    end else begin
      mem_ready = 1'b0;
    end
    prev_stalled = mem_req && !mem_ready;
    prev_addr    = mem_addr;
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input vec_t v);
    @(negedge clk);
    n_txn = 0; n_res = 0; n_mis = 0; timing_viol = 0;
    cur_stall = int'(v.stall);
    in_dword = (v.sz == 2'd3);
    cmd_store = v.st; cmd_size = v.sz; cmd_signed = v.sg; cmd_imm_sel = v.im;
    cmd_rs1 = v.a; cmd_rs2 = v.b; cmd_imm = v.imm;
    cmd_wdata_even = v.wde; cmd_wdata_odd = v.wdo;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    in_dword = 1'b0;
  endtask

  function automatic logic [31:0] ref_ea(input vec_t v);
    return v.a + (v.im ? {{19{v.imm[12]}}, v.imm} : v.b);
  endfunction

  task automatic check_vec(input int idx, input vec_t v);
    logic [31:0] ea = ref_ea(v);
    int nb = 1 << v.sz;
    logic bad = (v.sz == 2'd1 && ea[0]) || (v.sz == 2'd2 && ea[1:0] != 0) ||
                (v.sz == 2'd3 && ea[2:0] != 0);
    int beats = (v.sz == 2'd3) ? 2 : 1;
    string addr_req = v.im ? "R2" : "R1";
    if (bad) begin
      chk(n_mis == 1, "R3", $sformatf("vec%0d misalign pulses", idx), n_mis, 1);
      chk(n_txn == 0, "R3", $sformatf("vec%0d requests on misalign", idx), n_txn, 0);
      chk(n_res == 0, "R3", $sformatf("vec%0d results on misalign", idx), n_res, 0);
      chk(cmd_ready, "R3", $sformatf("vec%0d ready after misalign", idx), cmd_ready, 1);
      return;
    end
    chk(n_mis == 0, "R3", $sformatf("vec%0d spurious misalign", idx), n_mis, 0);
    chk(n_txn == beats, "R7", $sformatf("vec%0d request count", idx), n_txn, beats);
    if (n_txn != beats) return;
    for (int bt = 0; bt < beats; bt++) begin
      logic [31:0] ba = ea + 32'(4 * bt);
      chk(t_addr[bt] == ba, (bt == 0) ? addr_req : "R7",
          $sformatf("vec%0d beat%0d addr", idx, bt), t_addr[bt], ba);
      chk(t_we[bt] == v.st, v.st ? "R4" : "R5",
          $sformatf("vec%0d beat%0d we", idx, bt), t_we[bt], v.st);
      if (v.st) begin
        logic [31:0] src = (bt == 0) ? v.wde : v.wdo;
        int n = (nb > 4) ? 4 : nb;
        logic [3:0] ebe = '0;
        logic [31:0] ewd = '0;
        for (int k = 0; k < 4; k++) begin
          if (k >= int'(ea[1:0]) && k < int'(ea[1:0]) + n) ebe[3-k] = 1'b1;
          ewd[31-8*k -: 8] = src[8*(n-1-(k % n)) +: 8];
        end
        chk(t_be[bt] == ebe, (beats == 2) ? "R7" : "R4",
            $sformatf("vec%0d beat%0d byte enables", idx, bt), t_be[bt], ebe);
        chk(t_wd[bt] == ewd, (beats == 2) ? "R7" : "R4",
            $sformatf("vec%0d beat%0d wdata", idx, bt), t_wd[bt], ewd);
      end
    end
    if (v.st) begin
      chk(n_res == 0, "R4", $sformatf("vec%0d no result on store", idx), n_res, 0);
    end else begin
      chk(n_res == beats, "R9", $sformatf("vec%0d result count", idx), n_res, beats);
      chk(timing_viol == 0, "R9", $sformatf("vec%0d result latency", idx), timing_viol, 0);
      if (n_res == beats) begin
        for (int bt = 0; bt < beats; bt++) begin
          logic [31:0] w = mem_word((ea & 32'hFFFF_FFFC) + 32'(4 * bt));
          logic [31:0] e = '0;
          if (nb >= 4) e = w;
          else begin
            for (int j = 0; j < nb; j++) e = (e << 8) | 32'(w[8*(3-(int'(ea[1:0])+j)) +: 8]);
            if (v.sg && e[8*nb-1]) e = e | ~((32'h1 << (8*nb)) - 1);
          end
          chk(r_data[bt] == e, (nb < 4) ? (v.sg ? "R6" : "R5") : "R5",
              $sformatf("vec%0d result%0d data", idx, bt), r_data[bt], e);
          chk(r_odd[bt] == (bt == 1), "R7",
              $sformatf("vec%0d result%0d odd flag", idx, bt), r_odd[bt], bt);
        end
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state, observed while reset is held
    chk(!busy && !mem_req && !res_valid && !misalign, "R8", "outputs idle in reset",
        {28'h0, busy, mem_req, res_valid, misalign}, 32'h0);
    chk(cmd_ready, "R8", "ready in reset", cmd_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && cmd_ready, "R8", "idle after reset", {30'h0, busy, cmd_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i]);
      check_vec(i, VECS[i]);
    end

    // R2 directed: rs2 must not change the address in immediate mode
    begin
      vec_t v = '{1'b0, 2'd2, 1'b0, 1'b1, 32'h0000_B000, 32'hFFFF_FFF0, 13'h0FFC, 32'h0, 32'h0, 2'd0};
      run_op(v);
      chk(n_txn == 1 && t_addr[0] == 32'h0000_BFFC, "R2", "rs2 ignored with immediate",
          t_addr[0], 32'h0000_BFFC);
    end

    // R1 directed: address wraps modulo 2^32
    begin
      vec_t v = '{1'b0, 2'd2, 1'b0, 1'b0, 32'hFFFF_FFF8, 32'h0000_0010, 13'h0, 32'h0, 32'h0, 2'd1};
      run_op(v);
      chk(n_txn == 1 && t_addr[0] == 32'h0000_0008, "R1", "address wrap",
          t_addr[0], 32'h0000_0008);
    end

    chk(ready_viol == 0, "R8", "cmd_ready low while busy", ready_viol, 0);
    chk(hold_viol == 0, "R8", "request held stable while stalled", hold_viol, 0);
    chk(gap_viol == 0, "R8", "busy held between doubleword beats", gap_viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule